// File: doc/BRIEF.md
# Prescaled Timebase Counter with Alignment Modes

This block is the counting core of a general-purpose timer. A programmable prescaler divides the input clock into count ticks. Each tick moves a counter that runs between zero and an auto-reload period. The counter can run edge-aligned, counting only up or only down. It can also run center-aligned, sweeping up to the period and back down to zero. There are three center variants, and they differ only in which turning point produces an update event.

The period can be applied two ways. In shadowed mode a newly presented period is held back until the next update event. In immediate mode it takes effect at once. Each update event produces a one-cycle pulse and sets a sticky flag, which stays set until it is cleared. In one-pulse operation the counter stops itself at the first update event. In continuous operation it keeps running.

Top module: `tmr_timebase`

## Requirements
- R1: With prescale value P the counter takes exactly one step every P+1 clock cycles while running; the prescaler restarts from zero whenever the counter is not running.
- R2: Edge-aligned up-counting (align_i = 0, dir_i = 0) steps 0, 1, … up to the active period and then wraps to 0, raising upd_o for one cycle at the wrap; a period of 0 gives an update on every step.
- R3: Edge-aligned down-counting (align_i = 0, dir_i = 1) decrements by one and, on a step taken from 0, loads the active period and raises upd_o for one cycle; dir_o reads 1.
- R4: In any center mode (align_i = 1, 2 or 3) the counter starts upward from its held value, counts up to the period, then counts down to 0 and turns again; dir_i has no effect, and dir_o reports 0 while rising and 1 while falling.
- R5: Center mode with align_i = 1 raises upd_o only on the bottom turn (the step leaving 0 while falling).
- R6: Center mode with align_i = 2 raises upd_o only on the top turn (the step leaving the period while rising).
- R7: Center mode with align_i = 3 raises upd_o on both the top and the bottom turn.
- R8: With preload_i = 1, a period change made while running is ignored until the next update event, where the new value becomes active; while stopped, the active period follows period_i.
- R9: With preload_i = 0, a period change takes effect on the very next step.
- R10: With one_pulse_i = 1 the counter stops (run_o = 0, count held) right after the first update event and stays stopped until en_i is deasserted and asserted again.
- R11: With one_pulse_i = 0 the counter keeps running across update events.
- R12: upd_flag_o is set by each update event, holds until flag_clr_i is asserted, and an update event in the same cycle as the clear wins.
- R13: After reset, count_o, dir_o, upd_o, upd_flag_o and run_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run request |
| psc_i | input | PSC_W | Prescale value P, step every P+1 cycles |
| period_i | input | CNT_W | Auto-reload period |
| align_i | input | 2 | 0 edge, 1 center bottom, 2 center top, 3 center both |
| dir_i | input | 1 | Edge direction: 0 up, 1 down |
| preload_i | input | 1 | 1 shadows period changes until an update |
| one_pulse_i | input | 1 | 1 stops the counter at the first update |
| flag_clr_i | input | 1 | Clears the sticky update flag |
| count_o | output | CNT_W | Current count |
| dir_o | output | 1 | Current count direction, 1 = down |
| upd_o | output | 1 | One-cycle update event pulse |
| upd_flag_o | output | 1 | Sticky update flag |
| run_o | output | 1 | Counter is running |

## Verification
The situation that is hardest to reach from the ports is a period change that lands in the middle of a running sweep. The shadowed and immediate paths only give different counts in the steps between that change and the next update event. The bench starts a short edge-up count and changes period_i two steps in, before the counter reaches the old period. It then samples the count one step past the old wrap point, where a shadowed period shows 0 and an immediate one shows 4. Center turns are reached with small periods and a nonzero prescale, so that several top and bottom turns happen within one vector, and the update pulses are counted per turn type.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ALIGN_EDGE     = 2'd0,
    ALIGN_CTR_LO   = 2'd1,
    ALIGN_CTR_HI   = 2'd2,
    ALIGN_CTR_BOTH = 2'd3
  } align_e;

  localparam logic DIR_UP = 1'b0;
  localparam logic DIR_DN = 1'b1;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] div_q;

  assign tick_o = run_i && (div_q >= psc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_q <= '0;
    else if (!run_i)  div_q <= '0;
    else if (tick_o)  div_q <= '0;
    else              div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/tmr_arr_ctl.sv
module tmr_arr_ctl #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             pre_i,
  input  logic             evt_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] arr_o
);
  logic [CNT_W-1:0] shadow_q;
  logic             load;

  // stopped or immediate: track input; shadowed: take new value on update
  assign load  = !pre_i || !run_i || evt_i;
  assign arr_o = pre_i ? shadow_q : period_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   shadow_q <= '0;
    else if (load) shadow_q <= period_i;
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  align_e           align_i,
  input  logic             dir_i,
  input  logic [CNT_W-1:0] arr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             evt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;
  logic             is_ctr, evt_top, evt_bot;

  assign is_ctr  = (align_i != ALIGN_EDGE);
  assign evt_top = (align_i == ALIGN_CTR_HI) || (align_i == ALIGN_CTR_BOTH);
  assign evt_bot = (align_i == ALIGN_CTR_LO) || (align_i == ALIGN_CTR_BOTH);

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    evt_o = 1'b0;
    if (!is_ctr)     dir_d = dir_i;
    else if (!run_i) dir_d = DIR_UP;
    if (tick_i) begin
      if (!is_ctr) begin
        if (dir_i == DIR_UP) begin
          if (cnt_q >= arr_i) begin
            cnt_d = '0;
            evt_o = 1'b1;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end else begin
          if (cnt_q == '0) begin
            cnt_d = arr_i;
            evt_o = 1'b1;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
      end else if (dir_q == DIR_UP) begin
        if (cnt_q >= arr_i) begin
          cnt_d = (arr_i == '0) ? '0 : arr_i - ONE;
          dir_d = DIR_DN;
          evt_o = evt_top;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end else begin
        if (cnt_q == '0) begin
          cnt_d = (arr_i == '0) ? '0 : ONE;
          dir_d = DIR_UP;
          evt_o = evt_bot;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o = cnt_q;
  assign dir_o = dir_q;
endmodule

// File: rtl/tmr_timebase.sv
module tmr_timebase
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [1:0]       align_i,
  input  logic             dir_i,
  input  logic             preload_i,
  input  logic             one_pulse_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_o,
  output logic             upd_o,
  output logic             upd_flag_o,
  output logic             run_o
);
  logic             run_w, tick_w, evt_w;
  logic [CNT_W-1:0] arr_w;
  logic             stop_q, upd_q, flag_q;
  align_e           align_w;

  assign align_w = align_e'(align_i);
  assign run_w   = en_i && !stop_q;

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_w),
    .psc_i  (psc_i),
    .tick_o (tick_w)
  );

  tmr_arr_ctl #(.CNT_W(CNT_W)) u_arr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_w),
    .pre_i    (preload_i),
    .evt_i    (evt_w),
    .period_i (period_i),
    .arr_o    (arr_w)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_w),
    .tick_i  (tick_w),
    .align_i (align_w),
    .dir_i   (dir_i),
    .arr_i   (arr_w),
    .cnt_o   (count_o),
    .dir_o   (dir_o),
    .evt_o   (evt_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b0;
      upd_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      upd_q <= evt_w;
      // one-pulse latch, rearmed by dropping the run request
      if (!en_i)                    stop_q <= 1'b0;
      else if (evt_w && one_pulse_i) stop_q <= 1'b1;
      if (evt_w)           flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign upd_o      = upd_q;
  assign upd_flag_o = flag_q;
  assign run_o      = run_w;
endmodule

// File: rtl/tmr_timebase_chk.sv
module tmr_timebase_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_w,
  input logic [CNT_W-1:0] arr_w,
  input logic [1:0]       align_i,
  input logic             dir_i,
  input logic             one_pulse_i,
  input logic             flag_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             dir_o,
  input logic             upd_o,
  input logic             upd_flag_o,
  input logic             run_o
);
  AST_STEP_ON_TICK_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_w |=> $stable(count_o)); // R1

  AST_EDGE_UP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_w && align_i == 2'd0 && !dir_i && count_o < arr_w)
    |=> count_o == CNT_W'($past(count_o) + 1'b1)); // R2

  AST_EDGE_DN_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_w && align_i == 2'd0 && dir_i && count_o == '0) |=> upd_o); // R3

  AST_CTR_LO_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o && align_i == 2'd1 && $past(align_i) == 2'd1) |-> !dir_o); // R5

  AST_CTR_HI_TURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o && align_i == 2'd2 && $past(align_i) == 2'd2) |-> dir_o); // R6

  AST_ONE_PULSE_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_o && $past(one_pulse_i)) |-> !run_o); // R10

  AST_FLAG_ON_UPD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> upd_flag_o); // R12

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_flag_o && !flag_clr_i) |=> upd_flag_o); // R12
endmodule

bind tmr_timebase tmr_timebase_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_w      (tick_w),
  .arr_w       (arr_w),
  .align_i     (align_i),
  .dir_i       (dir_i),
  .one_pulse_i (one_pulse_i),
  .flag_clr_i  (flag_clr_i),
  .count_o     (count_o),
  .dir_o       (dir_o),
  .upd_o       (upd_o),
  .upd_flag_o  (upd_flag_o),
  .run_o       (run_o)
);

// File: tb/tmr_timebase_bench.sv
module tmr_timebase_bench;
  localparam int CNT_W  = 16;
  localparam int PSC_W  = 16;
  localparam int CLK_PS = 10;
  localparam int NVEC   = 9;

  typedef struct packed {
    logic [1:0] align;
    logic       dir;
    logic [7:0] psc;
    logic [7:0] per;
    logic [7:0] cycles;
    logic [7:0] exp_cnt;
    logic [7:0] exp_upd;
    logic       exp_dir;
  } vec_t;

  // align, dir, psc, period, cycles, expected count, update pulses, direction
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 8'd0, 8'd4, 8'd12, 8'd2, 8'd2, 1'b0}, // R2
    '{2'd0, 1'b0, 8'd2, 8'd3, 8'd20, 8'd2, 8'd1, 1'b0}, // R1
    '{2'd0, 1'b1, 8'd0, 8'd3, 8'd6,  8'd2, 8'd2, 1'b1}, // R3
    '{2'd1, 1'b0, 8'd0, 8'd3, 8'd14, 8'd2, 8'd2, 1'b0}, // R5
    '{2'd2, 1'b0, 8'd0, 8'd3, 8'd11, 8'd1, 8'd2, 1'b1}, // R6
    '{2'd3, 1'b0, 8'd1, 8'd2, 8'd20, 8'd2, 8'd4, 1'b0}, // R7
    '{2'd1, 1'b1, 8'd0, 8'd2, 8'd9,  8'd1, 8'd2, 1'b0}, // R4
    '{2'd0, 1'b1, 8'd3, 8'd5, 8'd16, 8'd2, 8'd1, 1'b1}, // R1
    '{2'd0, 1'b0, 8'd0, 8'd0, 8'd5,  8'd0, 8'd5, 1'b0}  // R2
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             en = 1'b0;
  logic [PSC_W-1:0] psc = '0;
  logic [CNT_W-1:0] period = '0;
  logic [1:0]       align = 2'd0;
  logic             dir = 1'b0;
  logic             pre = 1'b0;
  logic             op = 1'b0;
  logic             clr = 1'b0;
  logic [CNT_W-1:0] count;
  logic             dir_out, upd, flag, run;

  int n_chk = 0;
  int n_bad = 0;
  int n_upd;

  always #(CLK_PS/2) clk = ~clk;

  tmr_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tmr_timebase (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .psc_i       (psc),
    .period_i    (period),
    .align_i     (align),
    .dir_i       (dir),
    .preload_i   (pre),
    .one_pulse_i (op),
    .flag_clr_i  (clr),
    .count_o     (count),
    .dir_o       (dir_out),
    .upd_o       (upd),
    .upd_flag_o  (flag),
    .run_o       (run)
  );

  function automatic string vec_req(int i);
    case (i)
      0, 8:    return "R2";
      1, 7:    return "R1";
      2:       return "R3";
      3:       return "R5";
      4:       return "R6";
      5:       return "R7";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    en = 1'b0; clr = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // enable at a negedge, then count update pulses over n rising edges
  task automatic run_edges(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 0) en = 1'b1;
      @(posedge clk);
      #1;
      if (upd) n_upd++;
    end
    @(negedge clk);
  endtask

  task automatic more_edges(int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
      if (upd) n_upd++;
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R13: reset state
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13", "count", int'(count), 0);
    chk("R13", "dir", int'(dir_out), 0);
    chk("R13", "upd", int'(upd), 0);
    chk("R13", "flag", int'(flag), 0);
    chk("R13", "run", int'(run), 0);

    for (int i = 0; i < NVEC; i++) begin
      do_reset();
      align  = VECS[i].align;
      dir    = VECS[i].dir;
      psc    = PSC_W'(VECS[i].psc);
      period = CNT_W'(VECS[i].per);
      pre    = 1'b0;
      op     = 1'b0;
      n_upd  = 0;
      // run_edges performs its first edge after enabling
      for (int k = 0; k < int'(VECS[i].cycles); k++) begin
        @(negedge clk);
        en = 1'b1;
        @(posedge clk);
        #1;
        if (upd) n_upd++;
      end
      @(negedge clk);
      chk(vec_req(i), "count", int'(count), int'(VECS[i].exp_cnt));
      chk(vec_req(i), "updates", n_upd, int'(VECS[i].exp_upd));
      chk(vec_req(i), "dir", int'(dir_out), int'(VECS[i].exp_dir));
    end

    // R12: flag holds after stop, clears on request, set beats clear
    do_reset();
    align = 2'd0; dir = 1'b0; psc = '0; period = CNT_W'(1); pre = 1'b0; op = 1'b0;
    n_upd = 0;
    run_edges(4);
    en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12", "flag held", int'(flag), 1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R12", "flag cleared", int'(flag), 0);
    period = '0;
    clr = 1'b1;
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12", "set over clear", int'(flag), 1);
    clr = 1'b0;

    // R8: shadowed period change waits for the update
    do_reset();
    align = 2'd0; dir = 1'b0; psc = '0; period = CNT_W'(3); pre = 1'b1; op = 1'b0;
    n_upd = 0;
    run_edges(2);
    period = CNT_W'(6);
    more_edges(2);
    chk("R8", "count at old wrap", int'(count), 0);
    more_edges(6);
    chk("R8", "count at new top", int'(count), 6);

    // R9: immediate period change
    do_reset();
    pre = 1'b0; period = CNT_W'(3);
    n_upd = 0;
    run_edges(2);
    period = CNT_W'(6);
    more_edges(2);
    chk("R9", "count past old wrap", int'(count), 4);

    // R10: one-pulse stops after first update
    do_reset();
    period = CNT_W'(2); op = 1'b1;
    n_upd = 0;
    run_edges(7);
    chk("R10", "count held", int'(count), 0);
    chk("R10", "run", int'(run), 0);
    chk("R10", "updates", n_upd, 1);
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    chk("R10", "rearmed run", int'(run), 1);

    // R11: continuous keeps going
    do_reset();
    period = CNT_W'(2); op = 1'b0;
    n_upd = 0;
    run_edges(7);
    chk("R11", "count", int'(count), 1);
    chk("R11", "run", int'(run), 1);
    chk("R11", "updates", n_upd, 2);

    finish_run();
  end
endmodule